// File: doc/BRIEF.md
# Two-Stage Filtered Warp Issue Scheduler

This block picks, every clock, up to two warp instructions to send to the execution units of one streaming multiprocessor. It is split into two stages so that the wide per-warp instruction store is not read for every resident warp on every cycle. The first stage is a cheap scan. Each resident warp has one readiness bit, formed from a register scoreboard. All warps are evaluated every cycle, and the warps whose operands are free are registered as a candidate mask. The first stage never looks at functional-unit availability, because that status can change before the candidate reaches the second stage.

The second stage reads only the entries named in the candidate mask. For each of those it checks the busy flag of the unit class the instruction needs. It then grants up to two instructions. Slot 0 prefers the warp that slot 0 issued last, if that warp is still eligible. Otherwise slot 0 takes the oldest eligible warp, and slot 1 takes the oldest eligible warp of a different unit class. The cost is exactly one extra cycle for any issue. Two counters let a testbench or performance monitor measure how many wide-store reads the filter saves: one counts first-stage checks and one counts second-stage reads.

An upstream decoder loads one instruction per warp. The load carries the opcode, the unit class and three register numbers: a destination and two sources. Writeback pulses clear scoreboard bits.

Top module: `warp_issue_filter`

## Requirements
- R1: After reset both issue slots are invalid and both counters read zero.
- R2: A resident warp passes the first stage only when none of its three registers (source 0, source 1, destination) is marked pending in that warp's scoreboard. A pending destination alone is enough to block it.
- R3: A ready instruction whose load is sampled at clock edge k appears on issue slot 0 after edge k+2, which is two cycles later. It stays valid for exactly one cycle. After a writeback that releases a blocked warp at edge k, the same warp issues at edge k+2.
- R4: `rd_count` grows each cycle by the number of warps held in the candidate mask. It does not change in any cycle in which the mask is empty.
- R5: `chk_count` grows each cycle by the number of resident entries, meaning entries that are loaded but not yet issued.
- R6: An instruction whose unit class has its `unit_busy` bit set is not issued. It issues at the first edge at which that bit is sampled low.
- R7: At most two instructions issue per cycle. When both slots are valid they carry different warps and different unit classes.
- R8: If the warp that slot 0 issued most recently is eligible again, slot 0 takes it ahead of any older eligible warp.
- R9: Apart from that preference, each slot takes the eligible warp that was loaded earliest. The warp index plays no part in this choice.
- R10: Issuing an instruction marks its destination register as pending. A later instruction of the same warp that reads that register waits until a writeback pulse for that warp and register clears the mark.
- R11: The unit class field is a binary index into `unit_busy`: value 0 selects bit 0, value 1 selects bit 1, value 2 selects bit 2. Values at or above NUNIT are treated as permanently busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load one instruction into a warp entry. The load is dropped if that warp is still resident. |
| ld_warp | input | WID_W | Warp to load |
| ld_op | input | OP_W | Opcode |
| ld_unit | input | UC_W | Unit class index |
| ld_dst | input | REG_W | Destination register |
| ld_src0 | input | REG_W | First source register |
| ld_src1 | input | REG_W | Second source register |
| wb_valid | input | 1 | Writeback pulse that clears one pending bit |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | REG_W | Register of the writeback |
| unit_busy | input | NUNIT | One busy flag per unit class dispatch port |
| iss_valid | output | 2 | Slot valid flags; bit 0 is slot 0 |
| iss_warp | output | 2*WID_W | Issued warps; slot 0 is in the low field |
| iss_op | output | 2*OP_W | Issued opcodes; slot 0 is in the low field |
| iss_unit | output | 2*UC_W | Issued unit classes; slot 0 is in the low field |
| chk_count | output | CNT_W | Accumulated first-stage checks |
| rd_count | output | CNT_W | Accumulated second-stage entry reads |

## Verification
Two things can happen in the same cycle: a grant to slot 0 and a grant to slot 1. Each slot applies the busy check and the age order to its own candidates, and slot 1 must also avoid slot 0's warp and slot 0's unit class. The bench provokes this by holding two unit classes busy while three warps load: two of them share a class and one uses the other class. It then releases both classes in one cycle. The expected result is the oldest warp on slot 0 and the other-class warp on slot 1 in that same cycle, with the remaining same-class warp issuing alone in the following cycle.

// File: rtl/warp_issue_filter.sv
`timescale 1ns/1ps
module warp_issue_filter #(
  parameter int NWARP = 48,
  parameter int NREG  = 16,
  parameter int NUNIT = 3,
  parameter int OP_W  = 8,
  parameter int CNT_W = 32,
  localparam int WID_W = $clog2(NWARP),
  localparam int REG_W = $clog2(NREG),
  localparam int UC_W  = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  input  logic [WID_W-1:0]    ld_warp,
  input  logic [OP_W-1:0]     ld_op,
  input  logic [UC_W-1:0]     ld_unit,
  input  logic [REG_W-1:0]    ld_dst,
  input  logic [REG_W-1:0]    ld_src0,
  input  logic [REG_W-1:0]    ld_src1,
  input  logic                wb_valid,
  input  logic [WID_W-1:0]    wb_warp,
  input  logic [REG_W-1:0]    wb_reg,
  input  logic [NUNIT-1:0]    unit_busy,
  output logic [1:0]          iss_valid,
  output logic [2*WID_W-1:0]  iss_warp,
  output logic [2*OP_W-1:0]   iss_op,
  output logic [2*UC_W-1:0]   iss_unit,
  output logic [CNT_W-1:0]    chk_count,
  output logic [CNT_W-1:0]    rd_count
);
  localparam int UC_N = 1 << UC_W;

  logic [NWARP-1:0] ent_v, cand_q, dep_ok, ready1, elig, elig1, old0, old1, gmask;
  logic [OP_W-1:0]  ent_op   [NWARP];
  logic [UC_W-1:0]  ent_unit [NWARP];
  logic [REG_W-1:0] ent_dst  [NWARP];
  logic [REG_W-1:0] ent_s0   [NWARP];
  logic [REG_W-1:0] ent_s1   [NWARP];
  logic [NREG-1:0]  pend     [NWARP];
  logic [NWARP-1:0] older    [NWARP];
  logic [WID_W-1:0] last_w, g0, g1;
  logic             last_v, gv0, gv1;
  logic [UC_N-1:0]  busy_x;
  logic [WID_W:0]   n_cand, n_res;

  always_comb begin
    busy_x = '1;
    busy_x[NUNIT-1:0] = unit_busy;
  end

  // stage 1: scoreboard readiness; stage 2 inputs: candidates with a free port
  always_comb begin
    for (int i = 0; i < NWARP; i++) begin
      dep_ok[i] = !(pend[i][ent_s0[i]] || pend[i][ent_s1[i]] || pend[i][ent_dst[i]]);
      elig[i]   = cand_q[i] && !busy_x[ent_unit[i]];
    end
  end

  always_comb begin
    gv0 = 1'b0;
    g0  = '0;
    for (int i = 0; i < NWARP; i++)
      old0[i] = elig[i] && ((elig & older[i]) == '0);
    if (last_v && elig[last_w]) begin
      gv0 = 1'b1;
      g0  = last_w;
    end else begin
      for (int i = NWARP - 1; i >= 0; i--)
        if (old0[i]) begin
          gv0 = 1'b1;
          g0  = WID_W'(i);
        end
    end
    for (int i = 0; i < NWARP; i++)
      elig1[i] = elig[i] && gv0 && (WID_W'(i) != g0) && (ent_unit[i] != ent_unit[g0]);
    for (int i = 0; i < NWARP; i++)
      old1[i] = elig1[i] && ((elig1 & older[i]) == '0);
    gv1 = 1'b0;
    g1  = '0;
    for (int i = NWARP - 1; i >= 0; i--)
      if (old1[i]) begin
        gv1 = 1'b1;
        g1  = WID_W'(i);
      end
    gmask = '0;
    if (gv0) gmask[g0] = 1'b1;
    if (gv1) gmask[g1] = 1'b1;
  end

  assign ready1 = ent_v & dep_ok & ~gmask;

  always_comb begin
    n_cand = '0;
    n_res  = '0;
    for (int i = 0; i < NWARP; i++) begin
      n_cand = n_cand + {{WID_W{1'b0}}, cand_q[i]};
      n_res  = n_res  + {{WID_W{1'b0}}, ent_v[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v     <= '0;
      cand_q    <= '0;
      last_v    <= 1'b0;
      last_w    <= '0;
      iss_valid <= '0;
      iss_warp  <= '0;
      iss_op    <= '0;
      iss_unit  <= '0;
      chk_count <= '0;
      rd_count  <= '0;
      for (int i = 0; i < NWARP; i++) begin
        pend[i]     <= '0;
        older[i]    <= '0;
        ent_op[i]   <= '0;
        ent_unit[i] <= '0;
        ent_dst[i]  <= '0;
        ent_s0[i]   <= '0;
        ent_s1[i]   <= '0;
      end
    end else begin
      cand_q    <= ready1;
      chk_count <= chk_count + CNT_W'(n_res);
      rd_count  <= rd_count + CNT_W'(n_cand);
      iss_valid <= {gv1, gv0};
      iss_warp  <= {g1, g0};
      iss_op    <= {ent_op[g1], ent_op[g0]};
      iss_unit  <= {ent_unit[g1], ent_unit[g0]};
      if (wb_valid) pend[wb_warp][wb_reg] <= 1'b0;
      if (gv0) begin
        ent_v[g0]             <= 1'b0;
        pend[g0][ent_dst[g0]] <= 1'b1;
        last_w                <= g0;
        last_v                <= 1'b1;
      end
      if (gv1) begin
        ent_v[g1]             <= 1'b0;
        pend[g1][ent_dst[g1]] <= 1'b1;
      end
      if (ld_valid && !ent_v[ld_warp]) begin
        ent_v[ld_warp]    <= 1'b1;
        ent_op[ld_warp]   <= ld_op;
        ent_unit[ld_warp] <= ld_unit;
        ent_dst[ld_warp]  <= ld_dst;
        ent_s0[ld_warp]   <= ld_src0;
        ent_s1[ld_warp]   <= ld_src1;
        for (int k = 0; k < NWARP; k++) older[k][ld_warp] <= 1'b0;
        older[ld_warp]    <= ent_v & ~gmask;
      end
    end
  end

  assert_pair_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_valid) |-> (iss_warp[WID_W-1:0] != iss_warp[2*WID_W-1:WID_W]) &&
                     (iss_unit[UC_W-1:0] != iss_unit[2*UC_W-1:UC_W]));

  assert_port_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> ((($past(busy_x) >> iss_unit[UC_W-1:0]) & UC_N'(1)) == '0));

  assert_from_stage1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> |($past(cand_q) & (NWARP'(1) << iss_warp[WID_W-1:0])));

  assert_idle_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_q == '0) |=> $stable(rd_count));

  assert_slot1_needs_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> iss_valid[0]);
endmodule

// File: tb/warp_issue_filter_tb.sv
`timescale 1ns/1ps
module warp_issue_filter_tb;
  localparam int WW = 6, OPW = 8, UCW = 2, RW = 4, CW = 32, NU = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, wb_valid = 1'b0;
  logic [WW-1:0] ld_warp = '0, wb_warp = '0;
  logic [OPW-1:0] ld_op = '0;
  logic [UCW-1:0] ld_unit = '0;
  logic [RW-1:0] ld_dst = '0, ld_src0 = '0, ld_src1 = '0, wb_reg = '0;
  logic [NU-1:0] unit_busy = '0;
  logic [1:0] iss_valid;
  logic [2*WW-1:0] iss_warp;
  logic [2*OPW-1:0] iss_op;
  logic [2*UCW-1:0] iss_unit;
  logic [CW-1:0] chk_count, rd_count;

  warp_issue_filter u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_warp(ld_warp), .ld_op(ld_op),
    .ld_unit(ld_unit), .ld_dst(ld_dst), .ld_src0(ld_src0), .ld_src1(ld_src1),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .unit_busy(unit_busy),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_op(iss_op), .iss_unit(iss_unit),
    .chk_count(chk_count), .rd_count(rd_count));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [CW-1:0] rd0, chk0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int w, int op, int u, int d, int s0, int s1);
    ld_valid = 1'b1; ld_warp = WW'(w); ld_op = OPW'(op); ld_unit = UCW'(u);
    ld_dst = RW'(d); ld_src0 = RW'(s0); ld_src1 = RW'(s1);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic wb(int w, int r);
    wb_valid = 1'b1; wb_warp = WW'(w); wb_reg = RW'(r);
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic expect_none(string req);
    check(iss_valid == 2'b00, req, iss_valid, 0);
  endtask

  task automatic expect_slot0(string req, int w, int u);
    check(iss_valid[0] == 1'b1 && iss_warp[WW-1:0] == WW'(w) && iss_unit[UCW-1:0] == UCW'(u),
          req, iss_valid[0] ? iss_warp[WW-1:0] : -1, w);
  endtask

  task automatic t_reset();
    check(iss_valid == 2'b00, "R1 slots", iss_valid, 0);
    check(rd_count == 0 && chk_count == 0, "R1 counters", rd_count + chk_count, 0);
  endtask

  task automatic t_latency();
    rd0 = rd_count; chk0 = chk_count;
    load(5, 8'h21, 0, 1, 2, 3);
    expect_none("R3 after load edge");
    @(negedge clk); expect_none("R3 after stage1 edge");
    @(negedge clk);
    expect_slot0("R3 issue two cycles after load", 5, 0);
    check(iss_op[OPW-1:0] == 8'h21, "R3 opcode", iss_op[OPW-1:0], 8'h21);
    check(iss_valid[1] == 1'b0, "R7 lone instruction uses one slot", iss_valid[1], 0);
    check(rd_count - rd0 == 1, "R4 one read for one ready warp", rd_count - rd0, 1);
    check(chk_count - chk0 == 2, "R5 resident for two cycles", chk_count - chk0, 2);
    @(negedge clk); expect_none("R3 valid for one cycle");
  endtask

  task automatic t_src_pending();
    load(5, 8'h22, 1, 4, 1, 1);
    rd0 = rd_count; chk0 = chk_count;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); expect_none("R10 source pending blocks");
    end
    check(rd_count == rd0, "R4 blocked warp causes no read", rd_count - rd0, 0);
    check(chk_count - chk0 == 5, "R5 blocked warp still checked", chk_count - chk0, 5);
    wb(5, 1);
    expect_none("R10 after writeback edge");
    @(negedge clk); expect_none("R3 stage1 after writeback");
    @(negedge clk); expect_slot0("R10 issue after writeback", 5, 1);
    wb(5, 4);
  endtask

  task automatic t_dst_pending();
    load(6, 8'h71, 0, 7, 0, 0);
    @(negedge clk); @(negedge clk);
    expect_slot0("R2 free registers issue", 6, 0);
    load(6, 8'h72, 0, 7, 1, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); expect_none("R2 destination pending blocks");
    end
    wb(6, 7);
    @(negedge clk); @(negedge clk);
    expect_slot0("R2 released by destination writeback", 6, 0);
    wb(6, 7);
  endtask

  task automatic t_busy();
    unit_busy = 3'b100;
    load(8, 8'h33, 2, 5, 6, 7);
    rd0 = rd_count;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); expect_none("R6 busy unit class 2 blocks");
    end
    check(rd_count - rd0 == 3, "R4 waiting candidate read each cycle", rd_count - rd0, 3);
    unit_busy = 3'b000;
    @(negedge clk);
    expect_slot0("R11 unit 2 released issues", 8, 2);
    wb(8, 5);
  endtask

  task automatic t_oldest();
    unit_busy = 3'b001;
    load(9, 8'h41, 0, 8, 1, 2);
    load(4, 8'h42, 0, 9, 1, 2);
    @(negedge clk); @(negedge clk);
    unit_busy = 3'b000;
    @(negedge clk);
    expect_slot0("R9 older warp 9 before warp 4", 9, 0);
    check(iss_valid[1] == 1'b0, "R7 same class not paired", iss_valid[1], 0);
    @(negedge clk);
    expect_slot0("R9 younger warp next", 4, 0);
    wb(9, 8); wb(4, 9);
  endtask

  task automatic t_greedy();
    unit_busy = 3'b001;
    load(1, 8'h51, 0, 2, 3, 3);
    load(4, 8'h52, 0, 10, 11, 11);
    @(negedge clk); @(negedge clk);
    unit_busy = 3'b000;
    @(negedge clk);
    expect_slot0("R8 last issued warp 4 preferred", 4, 0);
    @(negedge clk);
    expect_slot0("R8 older warp follows", 1, 0);
    wb(1, 2); wb(4, 10);
  endtask

  task automatic t_dual();
    unit_busy = 3'b011;
    load(20, 8'h61, 0, 2, 3, 3);
    load(21, 8'h62, 0, 4, 3, 3);
    load(22, 8'h63, 1, 5, 3, 3);
    @(negedge clk); @(negedge clk);
    unit_busy = 3'b000;
    @(negedge clk);
    expect_slot0("R7 slot0 oldest", 20, 0);
    check(iss_valid[1] && iss_warp[2*WW-1:WW] == 6'd22 && iss_unit[2*UCW-1:UCW] == 2'd1,
          "R7 slot1 other class", iss_warp[2*WW-1:WW], 22);
    check(iss_op[2*OPW-1:OPW] == 8'h63, "R7 slot1 opcode", iss_op[2*OPW-1:OPW], 8'h63);
    @(negedge clk);
    expect_slot0("R7 leftover issues next", 21, 0);
    check(iss_valid[1] == 1'b0, "R7 leftover alone", iss_valid[1], 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    rd0 = rd_count; chk0 = chk_count;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); expect_none("R4 idle no issue");
    end
    check(rd_count == rd0, "R4 empty stage1 no read", rd_count - rd0, 0);
    check(chk_count == chk0, "R5 nothing resident", chk_count - chk0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_latency();
    t_src_pending();
    t_dst_pending();
    t_busy();
    t_oldest();
    t_greedy();
    t_dual();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule